// File: doc/BRIEF.md
# Pointer-Chasing Block Remap Controller

This controller sits between request logic and a wear-prone block memory. It serves block reads and writes of one data word each, and it retires worn blocks without a lookup table. A block that has worn out keeps a one-bit remap flag. Its remaining good cells hold three copies of the address of a spare block that now holds its contents. Every access therefore reads the original block first. If the flag is set, the controller takes a two-of-three vote on the pointer copies and then makes a second access to the spare.

An eight-entry direct-mapped translation cache remembers recent original-to-spare mappings. A hit skips the first memory read. Spares come from a bump allocator that hands out blocks upward from `SPARE_BASE` to the top of the address space. A retire request writes its data into the next spare, then marks the old block and stores the pointer in it. All of this logic lives in the controller. The memory stores a data word and a flag per block and nothing else.

The memory port is synchronous. A read issued in one cycle returns its data and flag in the next cycle. Only one request is handled at a time.

Top module: `blkremap_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0.
- R2: A read (`req_op` 0) of a block whose flag is clear, with no cache hit, returns the stored word with `rsp_remapped`=0 and `rsp_err`=0. `rsp_valid` rises 3 cycles after the acceptance cycle.
- R3: A write (`req_op` 1) to a block whose flag is clear, with no cache hit, first reads the block and then stores the word there with flag 0. The response comes 4 cycles after acceptance, with `rsp_remapped`=0.
- R4: A retire (`req_op` 2) with spares left allocates spares in ascending order, starting at `SPARE_BASE`. The request data goes into the spare with flag 0. The old block is then written with flag 1. In that word, bits [ADDR_W-1:0], [2*ADDR_W-1:ADDR_W] and [3*ADDR_W-1:2*ADDR_W] each hold the spare address, and all higher bits are 0. The response comes 3 cycles after acceptance, with `rsp_remapped`=1.
- R5: A read of a flagged block with no cache hit follows the stored pointer. It returns the spare's word with `rsp_remapped`=1, 5 cycles after acceptance, and leaves the original block unchanged.
- R6: On a cache hit the first read is skipped. A read of a remapped block then responds in 3 cycles and a write in 2, both with `rsp_remapped`=1.
- R7: The cache is indexed by address bits [2:0]. It is filled when a pointer is followed and when a retire completes. A remapped block with the same index evicts the previous entry, so the evicted block again costs 5 cycles.
- R8: A write to a remapped block stores the data in the spare and leaves the original block's flag and pointer word unchanged.
- R9: When exactly two pointer copies agree, their value is used as the spare address.
- R10: When all three pointer copies differ, the controller responds 3 cycles after acceptance with `rsp_err`=1, `rsp_rdata`=0 and `rsp_remapped`=0. It writes nothing to memory.
- R11: A retire when every spare is used responds 1 cycle after acceptance with `rsp_err`=1. It writes nothing to memory, and later accesses to that block are unaffected.
- R12: `req_ready` is 0 from the cycle after acceptance through the response cycle. `rsp_valid` lasts exactly one cycle, and `req_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 read, 1 write, 2 retire |
| req_addr | input | ADDR_W | Block address, below SPARE_BASE |
| req_wdata | input | DATA_W | Write or retire data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data, 0 for writes and errors |
| rsp_remapped | output | 1 | A remap was followed or created |
| rsp_err | output | 1 | Pointer vote failed or no spare left |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory block address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_wflag | output | 1 | Remap flag written with the word |
| mem_rdata | input | DATA_W | Read word, one cycle after the read |
| mem_rflag | input | 1 | Remap flag read with the word |

## Verification
The checker assumes that request addresses always fall below `SPARE_BASE`, so that spares are never addressed directly and pointers never chain. It also assumes that memory contents change only through the controller, except for the deliberately corrupted pointer blocks. The stimulus keeps every request inside the user region. Corrupted pointer words are placed only at addresses whose cache index holds no entry for them. After each pointer-corruption test, those blocks are left out of every later check, because spares they point to are reallocated later.

// File: rtl/blkremap_ctrl.sv
module blkremap_ctrl #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int SPARE_BASE = 48,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_remapped,
  output logic              rsp_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wflag,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rflag
);
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int BLOCKS  = 1 << ADDR_W;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ORIG, S_CHK_ORIG, S_RD_TGT, S_CHK_TGT,
    S_WR_DATA, S_RT_SPARE, S_RT_MARK, S_RESP
  } state_t;

  state_t            state;
  logic              op_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [DATA_W-1:0] rdata_q;
  logic              remap_q;
  logic              err_q;
  logic [ADDR_W:0]   free_q;

  logic              c_vld [ENTRIES];
  logic [TAG_W-1:0]  c_tag [ENTRIES];
  logic [ADDR_W-1:0] c_tgt [ENTRIES];

  logic [IDX_W-1:0]  req_idx;
  logic              hit;
  logic [ADDR_W-1:0] p0, p1, p2, voted;
  logic              vote_ok;
  logic              spares_left;
  logic              fill_en;
  logic [ADDR_W-1:0] fill_tgt;
  logic [ADDR_W-1:0] spare;

  assign req_idx     = req_addr[IDX_W-1:0];
  assign hit         = c_vld[req_idx] && (c_tag[req_idx] == req_addr[ADDR_W-1:IDX_W]);
  assign spares_left = free_q < (ADDR_W+1)'(BLOCKS);
  assign spare       = free_q[ADDR_W-1:0];

  assign p0      = mem_rdata[ADDR_W-1:0];
  assign p1      = mem_rdata[2*ADDR_W-1:ADDR_W];
  assign p2      = mem_rdata[3*ADDR_W-1:2*ADDR_W];
  assign vote_ok = (p0 == p1) || (p0 == p2) || (p1 == p2);
  assign voted   = ((p0 == p1) || (p0 == p2)) ? p0 : p1;

  assign fill_en  = ((state == S_CHK_ORIG) && mem_rflag && vote_ok) || (state == S_RT_MARK);
  assign fill_tgt = (state == S_RT_MARK) ? spare : voted;

  assign req_ready    = (state == S_IDLE);
  assign rsp_valid    = (state == S_RESP);
  assign rsp_rdata    = rdata_q;
  assign rsp_remapped = remap_q;
  assign rsp_err      = err_q;

  assign mem_req   = (state == S_RD_ORIG) || (state == S_RD_TGT) || (state == S_WR_DATA) ||
                     (state == S_RT_SPARE) || (state == S_RT_MARK);
  assign mem_we    = (state == S_WR_DATA) || (state == S_RT_SPARE) || (state == S_RT_MARK);
  assign mem_wflag = (state == S_RT_MARK);

  always_comb begin
    case (state)
      S_RD_TGT, S_WR_DATA: mem_addr = tgt_q;
      S_RT_SPARE:          mem_addr = spare;
      default:             mem_addr = addr_q;
    endcase
  end

  assign mem_wdata = (state == S_RT_MARK) ? DATA_W'({spare, spare, spare}) : wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) c_vld[i] <= 1'b0;
    end else if (fill_en) begin
      c_vld[addr_q[IDX_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      c_tag[addr_q[IDX_W-1:0]] <= addr_q[ADDR_W-1:IDX_W];
      c_tgt[addr_q[IDX_W-1:0]] <= fill_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      tgt_q   <= '0;
      rdata_q <= '0;
      remap_q <= 1'b0;
      err_q   <= 1'b0;
      free_q  <= (ADDR_W+1)'(SPARE_BASE);
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          op_wr   <= req_op[0];
          rdata_q <= '0;
          remap_q <= 1'b0;
          err_q   <= 1'b0;
          if (req_op[1]) begin
            if (spares_left) state <= S_RT_SPARE;
            else begin
              err_q <= 1'b1;
              state <= S_RESP;
            end
          end else if (hit) begin
            tgt_q   <= c_tgt[req_idx];
            remap_q <= 1'b1;
            state   <= req_op[0] ? S_WR_DATA : S_RD_TGT;
          end else begin
            state <= S_RD_ORIG;
          end
        end
        S_RD_ORIG: state <= S_CHK_ORIG;
        S_CHK_ORIG: begin
          if (!mem_rflag) begin
            tgt_q <= addr_q;
            if (op_wr) state <= S_WR_DATA;
            else begin
              rdata_q <= mem_rdata;
              state   <= S_RESP;
            end
          end else if (!vote_ok) begin
            err_q <= 1'b1;
            state <= S_RESP;
          end else begin
            tgt_q   <= voted;
            remap_q <= 1'b1;
            state   <= op_wr ? S_WR_DATA : S_RD_TGT;
          end
        end
        S_RD_TGT: state <= S_CHK_TGT;
        S_CHK_TGT: begin
          rdata_q <= mem_rdata;
          state   <= S_RESP;
        end
        S_WR_DATA:  state <= S_RESP;
        S_RT_SPARE: state <= S_RT_MARK;
        S_RT_MARK: begin
          free_q  <= free_q + 1'b1;
          remap_q <= 1'b1;
          state   <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module blkremap_chk #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int SPARE_BASE = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_remapped,
  input logic              rsp_err,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_wflag,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  localparam logic [ADDR_W-1:0] SPARE_A = ADDR_W'(SPARE_BASE);

  AST_REQ_USER_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr < SPARE_A); // R12
  AST_BUSY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R12
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R12
  AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req); // R1
  AST_ERR_NOT_REMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !rsp_remapped); // R10
  AST_MARK_POINTS_TO_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wflag) |-> (mem_wdata[ADDR_W-1:0] >= SPARE_A && mem_addr < SPARE_A)); // R4
  AST_MARK_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wflag) |->
      ($past(mem_req && mem_we && !mem_wflag) && $past(mem_addr) == mem_wdata[ADDR_W-1:0])); // R4
endmodule

bind blkremap_ctrl blkremap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPARE_BASE(SPARE_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_remapped(rsp_remapped), .rsp_err(rsp_err),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wflag(mem_wflag), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/blkremap_ctrl_tb_top.sv
module blkremap_ctrl_tb_top;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int SB = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_remapped, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req, mem_we, mem_wflag;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rflag = 1'b0;

  logic [DW-1:0] mem_d [64];
  logic          mem_f [64];
  int            wr_count = 0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] r_data;
  bit            r_rm, r_err, r_busy;
  int            r_lat;

  logic [DW-1:0] exp_d  [SB];
  bit            exp_rm [SB];
  int            exp_sp [SB];
  int            next_sp = SB;

  always #2 clk = ~clk;

  blkremap_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SPARE_BASE(SB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_remapped(rsp_remapped),
    .rsp_err(rsp_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wflag(mem_wflag), .mem_rdata(mem_rdata),
    .mem_rflag(mem_rflag)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem_d[mem_addr] <= mem_wdata;
        mem_f[mem_addr] <= mem_wflag;
        wr_count <= wr_count + 1;
      end else begin
        mem_rdata <= mem_d[mem_addr];
        mem_rflag <= mem_f[mem_addr];
      end
    end
  end

  function automatic logic [DW-1:0] pat(int a);
    return 32'h5A3C0000 ^ (32'(a) * 32'h01030507);
  endfunction

  function automatic logic [DW-1:0] ptrw(int p);
    return DW'(p) | (DW'(p) << AW) | (DW'(p) << (2*AW));
  endfunction

  task automatic chk(input string req, input string what, input bit ok,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input int a, input logic [DW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_wdata = wd;
    r_busy = req_ready;
    @(posedge clk);
    r_lat = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      r_lat++;
      if (req_ready) r_busy = 1'b0;
      if (rsp_valid) begin
        r_data = rsp_rdata; r_rm = rsp_remapped; r_err = rsp_err;
        break;
      end
      if (r_lat > 30) begin
        r_lat = 99; r_data = '0; r_rm = 0; r_err = 0;
        break;
      end
    end
    @(negedge clk);
    if (!req_ready || rsp_valid) r_busy = 1'b0;
    chk("R12", "handshake", r_busy, r_busy, 1);
  endtask

  task automatic retire(input int a, input logic [DW-1:0] d);
    int sp = next_sp;
    do_req(2'd2, a, d);
    chk("R4", "retire latency", r_lat == 3, r_lat, 3);
    chk("R4", "retire flags", r_rm && !r_err, {r_rm, r_err}, 2'b10);
    chk("R4", "spare data", mem_d[sp] == d && !mem_f[sp], mem_d[sp], d);
    chk("R4", "old flag", mem_f[a] == 1'b1, mem_f[a], 1);
    chk("R4", "pointer word", mem_d[a] == ptrw(sp), mem_d[a], ptrw(sp));
    exp_d[a] = d; exp_rm[a] = 1'b1; exp_sp[a] = sp;
    next_sp++;
  endtask

  task automatic rd_chk(input string req, input int a, input int lat);
    do_req(2'd0, a, '0);
    chk(req, "read data", r_data == exp_d[a], r_data, exp_d[a]);
    chk(req, "read remap", r_rm == exp_rm[a] && !r_err, {r_rm, r_err}, {exp_rm[a], 1'b0});
    if (lat > 0) chk(req, "read latency", r_lat == lat, r_lat, lat);
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int wc;
    logic [DW-1:0] nd;
    for (int i = 0; i < 64; i++) begin mem_d[i] = '0; mem_f[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1", "in reset", req_ready && !rsp_valid && !mem_req, {req_ready, rsp_valid, mem_req}, 3'b100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after reset", req_ready && !rsp_valid && !mem_req, {req_ready, rsp_valid, mem_req}, 3'b100);

    for (int a = 0; a < SB; a++) begin
      do_req(2'd1, a, pat(a));
      exp_d[a] = pat(a); exp_rm[a] = 1'b0; exp_sp[a] = a;
      chk("R3", "write latency", r_lat == 4, r_lat, 4);
      chk("R3", "write stored", mem_d[a] == pat(a) && !mem_f[a] && !r_rm, mem_d[a], pat(a));
    end
    for (int a = 0; a < SB; a++) rd_chk("R2", a, 3);

    retire(2, ~pat(2));
    retire(10, ~pat(10));
    retire(18, ~pat(18));
    retire(5, ~pat(5));
    rd_chk("R6", 5, 3);
    rd_chk("R6", 18, 3);
    rd_chk("R5", 2, 5);
    chk("R5", "original kept", mem_f[2] && mem_d[2] == ptrw(exp_sp[2]), mem_d[2], ptrw(exp_sp[2]));
    rd_chk("R6", 2, 3);
    rd_chk("R7", 10, 5);
    rd_chk("R7", 2, 5);

    nd = 32'hDEAD1010;
    do_req(2'd1, 10, nd);
    exp_d[10] = nd;
    chk("R8", "write miss latency", r_lat == 4 && r_rm, r_lat, 4);
    chk("R8", "target written", mem_d[exp_sp[10]] == nd, mem_d[exp_sp[10]], nd);
    chk("R8", "original untouched", mem_f[10] && mem_d[10] == ptrw(exp_sp[10]), mem_d[10], ptrw(exp_sp[10]));
    nd = 32'hBEEF1011;
    do_req(2'd1, 10, nd);
    exp_d[10] = nd;
    chk("R6", "write hit latency", r_lat == 2 && r_rm, r_lat, 2);
    chk("R8", "target rewritten", mem_d[exp_sp[10]] == nd, mem_d[exp_sp[10]], nd);

    @(negedge clk);
    mem_f[40] = 1'b1; mem_d[40] = DW'(63) | (DW'(7) << AW) | (DW'(63) << (2*AW));
    mem_d[63] = 32'hC0FFEE01; mem_f[63] = 1'b0;
    mem_f[41] = 1'b1; mem_d[41] = DW'(7) | (DW'(62) << AW) | (DW'(62) << (2*AW));
    mem_d[62] = 32'hC0FFEE02; mem_f[62] = 1'b0;
    mem_f[42] = 1'b1; mem_d[42] = DW'(61) | (DW'(62) << AW) | (DW'(63) << (2*AW));
    do_req(2'd0, 40, '0);
    chk("R9", "vote outer copies", r_data == 32'hC0FFEE01 && r_rm && !r_err, r_data, 32'hC0FFEE01);
    chk("R9", "vote latency", r_lat == 5, r_lat, 5);
    do_req(2'd0, 41, '0);
    chk("R9", "vote upper copies", r_data == 32'hC0FFEE02 && r_rm && !r_err, r_data, 32'hC0FFEE02);

    wc = wr_count;
    do_req(2'd0, 42, '0);
    chk("R10", "read vote fail", r_err && !r_rm && r_data == '0, {r_err, r_rm, r_data}, {2'b10, 32'h0});
    chk("R10", "fail latency", r_lat == 3, r_lat, 3);
    do_req(2'd1, 42, 32'h12345678);
    chk("R10", "write vote fail", r_err && !r_rm, {r_err, r_rm}, 2'b10);
    chk("R10", "no memory write", wr_count == wc, wr_count, wc);

    for (int a = 20; a < 32; a++) retire(a, pat(a) ^ 32'h0F0F0F0F);
    chk("R4", "all spares used", next_sp == 64, next_sp, 64);
    wc = wr_count;
    do_req(2'd2, 0, 32'hFFFFFFFF);
    chk("R11", "exhausted error", r_err && !r_rm, {r_err, r_rm}, 2'b10);
    chk("R11", "exhausted latency", r_lat == 1, r_lat, 1);
    chk("R11", "no memory write", wr_count == wc && !mem_f[0], wr_count, wc);
    rd_chk("R11", 0, 3);

    for (int a = 0; a < SB; a++)
      if (a < 40 || a > 42) rd_chk("R5", a, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule